// File: doc/BRIEF.md
# Fetch Target and Direction Predictor

This block sits in the fetch stage and picks the address to fetch next on every cycle. It combines two structures: a small fully associative target cache, looked up with the full fetch address, and a larger direct-mapped table of 2-bit saturating direction counters.

A hit in the target cache would mean "taken" on its own. The direction counter at the fetch address has the final word, though. The block predicts taken only when the target cache hits and the counter's upper bit is set. In that case the next fetch address is the stored target. In every other case it is the fetch address plus 4.

Both structures learn only from the resolution port that the branch execution unit drives. That port reports the branch address, the outcome, the resolved target and whether the branch was mispredicted. A mispredicted resolution redirects the next fetch address to the corrected path in the same cycle.

Top module: `fetch_predictor`

## Requirements
- R1: After reset no target cache entry is valid and every direction counter holds 01, so every lookup gives pred_taken=0 and next_pc=fetch_pc+4.
- R2: When fetch_pc matches a valid target cache entry and the upper bit of its direction counter is 1, pred_taken=1 and next_pc is the stored target.
- R3: When the target cache hits but the counter's upper bit is 0, pred_taken=0 and next_pc=fetch_pc+4; the counter overrides the hit.
- R4: When the target cache misses, pred_taken=0 and next_pc=fetch_pc+4 even if the counter's upper bit is 1.
- R5: The direction counter is chosen by address bits [10:2]. It counts up by one on a taken resolution and down by one on a not-taken resolution, and it saturates at 3 and at 0.
- R6: A taken resolution whose address misses in the target cache writes an entry at a round-robin pointer that starts at slot 0 and advances by one per allocation. After 64 further allocations the oldest entry is replaced. No address is held in two entries.
- R7: A taken resolution that hits rewrites that entry's target. A not-taken resolution leaves the target cache unchanged.
- R8: Resolutions take effect from the next cycle; a lookup in the same cycle sees the old contents.
- R9: When upd_valid and upd_mispredict are both 1, next_pc is upd_target if upd_taken=1 and upd_pc+4 otherwise. This holds for that cycle only, and pred_taken still shows the lookup's own prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Current fetch address |
| upd_valid | input | 1 | A branch resolution is present |
| upd_pc | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_target | input | ADDR_W | Resolved target address |
| upd_mispredict | input | 1 | The resolved branch was mispredicted |
| next_pc | output | ADDR_W | Address to fetch next |
| pred_taken | output | 1 | The lookup predicts a taken branch |

## Verification
Directed patterns separate the four cases of hit and counter bit. One case uses two addresses that share index bits [10:2] but differ above bit 10. That case distinguishes a counter-taken miss, which must stay sequential, from a true hit. Counter walks past both ends show saturation rather than wraparound. A run of 64 fresh allocations shows the round-robin eviction of the oldest entry. Resolutions that coincide with a lookup of the same address show that the old contents are used. Random resolutions over a small address pool with aliasing, compared against a bench model, mix target rewrites, evictions and redirects.

// File: rtl/fetch_predictor.sv
module fetch_predictor #(
  parameter int ADDR_W      = 32,
  parameter int TC_ENTRIES  = 64,
  parameter int DIR_ENTRIES = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_mispredict,
  output logic [ADDR_W-1:0] next_pc,
  output logic              pred_taken
);
  localparam int TC_IW  = $clog2(TC_ENTRIES);
  localparam int DIR_IW = $clog2(DIR_ENTRIES);

  logic [ADDR_W-1:0]     tc_tag [TC_ENTRIES];
  logic [ADDR_W-1:0]     tc_tgt [TC_ENTRIES];
  logic [TC_ENTRIES-1:0] tc_val;
  logic [1:0]            dir_ctr [DIR_ENTRIES];
  logic [TC_IW-1:0]      rr_ptr;

  logic [TC_ENTRIES-1:0] hit_vec, upd_hit_vec;
  logic [ADDR_W-1:0]     lk_tgt;
  logic [TC_IW-1:0]      upd_hit_idx;
  logic                  alloc;

  wire [DIR_IW-1:0] lk_idx = fetch_pc[DIR_IW+1:2];
  wire [DIR_IW-1:0] up_idx = upd_pc[DIR_IW+1:2];
  wire [1:0]        lk_ctr = dir_ctr[lk_idx];
  wire [1:0]        up_ctr = dir_ctr[up_idx];

  always_comb begin
    lk_tgt      = '0;
    upd_hit_idx = '0;
    for (int i = 0; i < TC_ENTRIES; i++) begin
      hit_vec[i]     = tc_val[i] && (tc_tag[i] == fetch_pc);
      upd_hit_vec[i] = tc_val[i] && (tc_tag[i] == upd_pc);
      if (hit_vec[i]) lk_tgt = lk_tgt | tc_tgt[i];
      if (upd_hit_vec[i]) upd_hit_idx = TC_IW'(i);
    end
  end

  assign pred_taken = (|hit_vec) && lk_ctr[1];
  assign alloc      = upd_valid && upd_taken && !(|upd_hit_vec);

  wire redirect = upd_valid && upd_mispredict;
  wire [ADDR_W-1:0] fix_pc = upd_taken ? upd_target : upd_pc + ADDR_W'(4);

  assign next_pc = redirect   ? fix_pc :
                   pred_taken ? lk_tgt : fetch_pc + ADDR_W'(4);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_val <= '0;
      rr_ptr <= '0;
      for (int i = 0; i < DIR_ENTRIES; i++) dir_ctr[i] <= 2'b01;
    end else if (upd_valid) begin
      if (upd_taken && up_ctr != 2'b11) dir_ctr[up_idx] <= up_ctr + 2'd1;
      else if (!upd_taken && up_ctr != 2'b00) dir_ctr[up_idx] <= up_ctr - 2'd1;
      if (alloc) begin
        tc_val[rr_ptr] <= 1'b1;
        rr_ptr <= (rr_ptr == TC_IW'(TC_ENTRIES-1)) ? '0 : rr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && upd_valid && upd_taken) begin
      if (alloc) begin
        tc_tag[rr_ptr] <= upd_pc;
        tc_tgt[rr_ptr] <= upd_target;
      end else begin
        tc_tgt[upd_hit_idx] <= upd_target;
      end
    end
  end
endmodule

// File: rtl/fetch_predictor_chk.sv
module fetch_predictor_chk #(
  parameter int ADDR_W     = 32,
  parameter int TC_ENTRIES = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     fetch_pc,
  input logic                  upd_valid,
  input logic [ADDR_W-1:0]     upd_pc,
  input logic                  upd_taken,
  input logic [ADDR_W-1:0]     upd_target,
  input logic                  upd_mispredict,
  input logic [ADDR_W-1:0]     next_pc,
  input logic                  pred_taken,
  input logic [TC_ENTRIES-1:0] hit_vec,
  input logic                  alloc,
  input logic [$clog2(TC_ENTRIES)-1:0] rr_ptr
);
  localparam int TC_IW = $clog2(TC_ENTRIES);

  a_r2_taken_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> (|hit_vec));

  a_r4_sequential: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_taken && !(upd_valid && upd_mispredict)) |-> next_pc == fetch_pc + ADDR_W'(4));

  a_r9_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_mispredict) |->
      next_pc == (upd_taken ? upd_target : upd_pc + ADDR_W'(4)));

  a_r6_unique_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r6_pointer_step: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> rr_ptr == (($past(rr_ptr) == TC_IW'(TC_ENTRIES-1)) ? '0 : $past(rr_ptr) + 1'b1));

  a_r6_pointer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc |=> $stable(rr_ptr));

  a_r8_alloc_visible: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (fetch_pc != $past(upd_pc) || (|hit_vec)));
endmodule

bind fetch_predictor fetch_predictor_chk #(.ADDR_W(ADDR_W), .TC_ENTRIES(TC_ENTRIES)) u_chk (.*);

// File: tb/fetch_predictor_test.sv
`timescale 1ns/1ps
module fetch_predictor_test;
  localparam int AW = 32;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] fetch_pc = 0, upd_pc = 0, upd_target = 0;
  logic upd_valid = 0, upd_taken = 0, upd_mispredict = 0;
  logic [AW-1:0] next_pc;
  logic pred_taken;

  fetch_predictor uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [AW-1:0] m_tag [64];
  logic [AW-1:0] m_tgt [64];
  bit            m_val [64];
  logic [1:0]    m_ctr [512];
  int            m_rr;

  function automatic int m_find(input logic [AW-1:0] pc);
    for (int i = 0; i < 64; i++) if (m_val[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  function automatic logic [AW:0] m_expect(input logic [AW-1:0] pc, input bit uv,
      input logic [AW-1:0] upc, input bit ut, input logic [AW-1:0] utg, input bit um);
    int h = m_find(pc);
    bit t = (h >= 0) && m_ctr[pc[10:2]][1];
    logic [AW-1:0] n = t ? m_tgt[h] : pc + 4;
    if (uv && um) n = ut ? utg : upc + 4;
    return {t, n};
  endfunction

  task automatic m_update(input logic [AW-1:0] upc, input bit ut, input logic [AW-1:0] utg);
    int h = m_find(upc);
    logic [1:0] c = m_ctr[upc[10:2]];
    if (ut && c != 3) m_ctr[upc[10:2]] = c + 1;
    if (!ut && c != 0) m_ctr[upc[10:2]] = c - 1;
    if (ut) begin
      if (h >= 0) m_tgt[h] = utg;
      else begin
        m_tag[m_rr] = upc; m_tgt[m_rr] = utg; m_val[m_rr] = 1;
        m_rr = (m_rr + 1) % 64;
      end
    end
  endtask

  task automatic cyc(input logic [AW-1:0] pc, input bit uv, input logic [AW-1:0] upc,
      input bit ut, input logic [AW-1:0] utg, input bit um, input string req);
    logic [AW:0] e;
    fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    upd_target = utg; upd_mispredict = um;
    #1;
    e = m_expect(pc, uv, upc, ut, utg, um);
    checks++;
    if (next_pc !== e[AW-1:0] || pred_taken !== e[AW]) begin
      failures++;
      $display("FAIL %s pc=%h next_pc=%h exp=%h pred_taken=%b exp=%b",
               req, pc, next_pc, e[AW-1:0], pred_taken, e[AW]);
    end
    @(posedge clk);
    if (uv) m_update(upc, ut, utg);
    @(negedge clk);
  endtask

  task automatic look(input logic [AW-1:0] pc, input string req);
    cyc(pc, 0, 0, 0, 0, 0, req);
  endtask

  task automatic res(input logic [AW-1:0] pc, input bit ut, input logic [AW-1:0] tg);
    cyc(32'h0000_0f00, 1, pc, ut, tg, 0, "R5 R8 background lookup");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  localparam logic [AW-1:0] A = 32'h0000_0100, C = 32'h0000_0900;

  initial begin
    for (int i = 0; i < 64; i++) m_val[i] = 0;
    for (int i = 0; i < 512; i++) m_ctr[i] = 2'b01;
    m_rr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    look(A, "R1 reset lookup");
    look(32'h0000_2344, "R1 reset lookup other");
    cyc(A, 1, A, 1, 32'h5000, 0, "R8 same-cycle lookup sees old");
    look(A, "R2 hit and counter taken");
    cyc(A, 1, A, 0, 0, 0, "R8 old contents during not-taken update");
    look(A, "R3 hit overridden by counter");
    res(A, 1, 32'h5000);
    look(C, "R4 aliased counter taken but miss");
    look(A, "R2 retrained hit");
    res(A, 1, 32'h6000);
    look(A, "R7 target rewritten");
    res(A, 1, 32'h6000);
    res(A, 0, 0);
    res(A, 0, 0);
    look(A, "R5 upper saturation");
    res(A, 0, 0); res(A, 0, 0); res(A, 1, 32'h6000); res(A, 1, 32'h6000);
    look(A, "R5 lower saturation");
    res(A, 0, 0);
    look(A, "R7 not-taken keeps entry");
    cyc(A, 1, 32'h0000_0200, 1, 32'h7700, 1, "R9 redirect to taken target");
    cyc(A, 1, 32'h0000_0300, 0, 32'h7700, 1, "R9 redirect to fall-through");
    res(A, 1, 32'h6000);
    for (int i = 0; i < 64; i++) res(32'h0000_4000 + i * 4, 1, 32'h8000 + i * 16);
    look(A, "R6 oldest entry evicted");
    look(32'h0000_4004, "R6 later entry kept");
    look(32'h0000_40fc, "R6 newest entry present");

    void'($urandom(1234));
    for (int n = 0; n < 4000; n++) begin
      logic [AW-1:0] p  = 32'h0000_3000 + ($urandom % 20) * 4 + (($urandom % 4 == 0) ? 32'h800 : 0);
      logic [AW-1:0] q  = 32'h0000_3000 + ($urandom % 20) * 4 + (($urandom % 4 == 0) ? 32'h800 : 0);
      logic [AW-1:0] tg = {$urandom % 32'h10000, 2'b00};
      bit uv = ($urandom % 3) != 0;
      bit ut = ($urandom % 2) == 0;
      bit um = ($urandom % 8) == 0;
      if ($urandom % 5 == 0) q = p;
      cyc(p, uv, q, ut, tg, um, "R2 R3 R4 R6 R7 R9 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule